// File: doc/BRIEF.md
# Cascaded Bidirectional Column Strobe Sequencer

This block is the timing core of a display column driver. A horizontal start pulse arms it. A delay counter then waits for this chip's turn within a chain of up to four chips. When the wait ends, the block walks a sampling strobe across its output columns, one column or three columns at a time. The walk goes left to right or right to left, as the direction input selects. A discharge output follows the start pulse at a fixed lag, and the analog side uses it to drop all columns before new data is driven.

The shift clock is an input that is oversampled by the system clock. Every change of the shift clock, rising or falling, is one step. A strobe stays on for two steps, which is one full shift-clock period. Adjacent strobes therefore overlap by one step. Each chip finds its own place in the chain from two position pins, so no carry signal passes between chips.

Top module: `colstrobe_seq`

## Requirements
- R1: While reset is low, and after its release until the first start pulse, every strobe bit and the discharge output are 0.
- R2: With `dir_fwd`=1 in single mode, group j (j=0 to COLS-1) is column j, which is bit j of `strobe`. Group j turns on after the step numbered D+j.
- R3: With `dir_fwd`=0, the order is mirrored. Group NG-1-j turns on after step D+j, where NG is the number of groups.
- R4: A strobe turns on after one step and stays on for exactly two steps. Because of this, at most two adjacent groups are on at any time.
- R5: With `triple`=1, group g is columns 3g, 3g+1 and 3g+2. These three bits always switch together, and NG=COLS/3.
- R6: Steps are numbered from the first step that samples `start` low after it was high (step 0). For the first chip, D = 2*BASE_CYC half-steps, which is 30 with the default of 15 shift-clock cycles.
- R7: `{pos_b,pos_a}` = 11, 10, 01 and 00 select positions 1, 2, 3 and 4. Position k adds (k-1)*NG steps to D.
- R8: After each step, `dis` equals the value `start` had 2*DIS_LAG steps earlier. With the defaults this is a lag of 6 half-steps, or 3 shift-clock cycles.
- R9: If a step samples `start` high, all strobes are 0 after that step. Any scan in progress is abandoned, and the delay starts again at the next falling edge of `start`.
- R10: No strobe bit is 1 while `dis` is 1.
- R11: `strobe` and `dis` change only in the system-clock cycle that follows a change of `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples `sclk` |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Shift clock; each edge of it is one step |
| start | input | 1 | Horizontal start pulse, sampled on steps |
| dir_fwd | input | 1 | 1 = ascending column order, 0 = descending |
| triple | input | 1 | 1 = three columns per group, 0 = one column |
| pos_a | input | 1 | Chain position code, low bit (R7) |
| pos_b | input | 1 | Chain position code, high bit (R7) |
| strobe | output | COLS | One sampling strobe per column |
| dis | output | 1 | Discharge signal |

## Verification
A corrupted step counter or group index shows up at the ports within a single step. Either a strobe appears for the wrong column, or it appears on the wrong step and moves the whole scan, and the per-step comparison of the full vector catches both. A fault in the delay counter moves the first strobe by whole steps, so it is seen at the first expected strobe of the affected scan. A wrong discharge history is seen within six steps of the next start edge. A failure to clear on a new start pulse is seen on the very next step.

// File: rtl/colstrobe_seq.sv
module colstrobe_seq #(
  parameter int COLS     = 240,
  parameter int BASE_CYC = 15,
  parameter int DIS_LAG  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            start,
  input  logic            dir_fwd,
  input  logic            triple,
  input  logic            pos_a,
  input  logic            pos_b,
  output logic [COLS-1:0] strobe,
  output logic            dis
);
  localparam int GW    = 3;
  localparam int NG_T  = COLS / GW;
  localparam int LAG   = 2 * DIS_LAG;
  localparam int BASE2 = 2 * BASE_CYC;
  localparam int CW    = $clog2(BASE2 + 3 * COLS + 2);
  localparam int GIW   = $clog2(COLS + 1);

  typedef enum logic [1:0] {IDLE, HOLD, WAIT, SCAN} st_t;

  st_t            st;
  logic           sclk_q;
  logic [LAG:0]   hist;
  logic [CW-1:0]  cnt;
  logic [GIW-1:0] lg, tg;
  logic           lv, tv;

  wire            ev    = sclk ^ sclk_q;
  wire [GIW-1:0]  ng    = triple ? GIW'(NG_T) : GIW'(COLS);
  wire [GIW-1:0]  first = dir_fwd ? '0 : ng - 1'b1;
  wire [GIW-1:0]  last  = dir_fwd ? ng - 1'b1 : '0;
  wire [1:0]      slot  = {~pos_b, ~pos_a};
  wire [CW-1:0]   delay = CW'(BASE2) + CW'(slot) * CW'(ng);

  assign dis = hist[LAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      sclk_q <= 1'b0;
      hist   <= '0;
      cnt    <= '0;
      lg     <= '0;
      tg     <= '0;
      lv     <= 1'b0;
      tv     <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (ev) begin
        hist <= {hist[LAG-1:0], start};
        if (start) begin
          st <= HOLD;
          lv <= 1'b0;
          tv <= 1'b0;
        end else begin
          case (st)
            HOLD: begin
              st  <= WAIT;
              cnt <= CW'(1);
            end
            WAIT: begin
              if (cnt == delay) begin
                st <= SCAN;
                lv <= 1'b1;
                lg <= first;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            SCAN: begin
              tv <= lv;
              tg <= lg;
              if (lv) begin
                if (lg == last) lv <= 1'b0;
                else lg <= dir_fwd ? lg + 1'b1 : lg - 1'b1;
              end else if (!tv) begin
                st <= IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int GT = c / GW;
    wire [GIW-1:0] gi = triple ? GIW'(GT) : GIW'(c);
    assign strobe[c] = (lv && lg == gi) || (tv && tg == gi);
  end
endmodule

// File: rtl/colstrobe_seq_chk.sv
module colstrobe_seq_chk #(
  parameter int COLS = 240
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sclk,
  input logic            start,
  input logic            triple,
  input logic [COLS-1:0] strobe,
  input logic            dis
);
  logic ckq;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ckq <= 1'b0;
    else ckq <= sclk;
  wire edge_seen = sclk ^ ckq;

  a_r10_quiet_in_discharge: assert property (@(posedge clk) disable iff (!rst_n)
    dis |-> (strobe == '0));

  a_r4_two_groups: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(strobe) <= (triple ? 6 : 2));

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && start) |=> (strobe == '0));

  a_r11_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_seen |=> ($stable(strobe) && $stable(dis)));
endmodule

bind colstrobe_seq colstrobe_seq_chk #(.COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .start(start),
  .triple(triple), .strobe(strobe), .dis(dis)
);

// File: tb/sim_colstrobe_seq.sv
module sim_colstrobe_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COLS = 240;
  localparam int LAG  = 6;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, start = 1'b0;
  logic dir_fwd = 1'b1, triple = 1'b0, pos_a = 1'b1, pos_b = 1'b1;
  logic [COLS-1:0] strobe;
  logic dis;
  int checks = 0, fails = 0, evn = 0;
  bit hist [0:7];
  bit done = 0;

  colstrobe_seq u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .start(start),
    .dir_fwd(dir_fwd), .triple(triple), .pos_a(pos_a), .pos_b(pos_b),
    .strobe(strobe), .dis(dis));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic step();
    logic [COLS-1:0] v1;
    logic d1, de;
    @(negedge clk);
    hist[evn % 8] = start;
    sclk = ~sclk;
    @(negedge clk);
    v1 = strobe; d1 = dis;
    de = (evn >= LAG) ? hist[(evn - LAG) % 8] : 1'b0;
    chk(dis === de, "R8", $sformatf("dis act=%0b exp=%0b step=%0d", dis, de, evn));
    repeat (3) @(negedge clk);
    chk(strobe === v1 && dis === d1, "R11",
        $sformatf("outputs moved between steps act=%h exp=%h", strobe, v1));
    evn++;
  endtask

  function automatic logic [COLS-1:0] expect_vec(int rel, bit d, bit t, int k);
    logic [COLS-1:0] v = '0;
    int ng = t ? COLS / 3 : COLS;
    int dd = 30 + (k - 1) * ng;
    for (int c = 0; c < COLS; c++) begin
      int g = t ? c / 3 : c;
      int j = d ? g : ng - 1 - g;
      v[c] = (rel == dd + j) || (rel == dd + j + 1);
    end
    return v;
  endfunction

  task automatic set_mode(bit d, bit t, int k);
    dir_fwd = d; triple = t;
    pos_a = !(((k - 1) & 1) != 0);
    pos_b = !(((k - 1) & 2) != 0);
  endtask

  // R2 R3 R4 R5 R6 R7 R10
  task automatic run_scan(bit d, bit t, int k);
    int ng = t ? COLS / 3 : COLS;
    int dd = 30 + (k - 1) * ng;
    int bad = 0;
    logic [COLS-1:0] e;
    set_mode(d, t, k);
    start = 1'b1;
    repeat (8) step();
    start = 1'b0;
    step();
    for (int rel = 1; rel <= dd + ng + 3; rel++) begin
      step();
      e = expect_vec(rel, d, t, k);
      if (strobe !== e) begin
        bad++;
        if (bad < 4)
          $display("FAIL R2/R3/R5/R6/R7 dir=%0b tri=%0b pos=%0d rel=%0d act=%h exp=%h",
                   d, t, k, rel, strobe, e);
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  // R9
  task automatic abort_scan();
    set_mode(1'b1, 1'b0, 1);
    start = 1'b1;
    repeat (8) step();
    start = 1'b0;
    step();
    for (int rel = 1; rel <= 35; rel++) step();
    chk(strobe !== '0, "R9", "scan not running before abort");
    start = 1'b1;
    step();
    chk(strobe === '0, "R9", $sformatf("abort act=%h exp=0", strobe));
    run_scan(1'b1, 1'b0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(strobe === '0 && dis === 1'b0, "R1",
        $sformatf("reset strobe=%h dis=%0b exp 0", strobe, dis));
    rst_n = 1'b1;
    repeat (2) step();
    chk(strobe === '0 && dis === 1'b0, "R1", "idle after reset not quiet");
    for (int t = 0; t < 2; t++)
      for (int d = 1; d >= 0; d--)
        for (int k = 1; k <= 4; k++)
          run_scan(d[0], t[0], k);
    abort_scan();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule